// File: doc/BRIEF.md
# Periodic Wheel Speed Counter

This block counts revolutions of a drive wheel or sprocket over a fixed sample window. A rotation sensor, such as a Hall-effect switch or a slotted optical interrupter, drives an asynchronous pulse input. The block brings that input into the clock domain and counts each rising edge. A programmable window timer runs from the system clock. At the end of each window it copies the running count into a read register and restarts the counter from zero in the same cycle, so software always sees a count per window rather than a running total.

Software reads the latched count through a small register port. It multiplies the count by the travel per revolution to get distance, and compares successive counts against expected values (and against motor current) to spot slip or a jammed track. A status register reports whether a fresh sample is waiting and whether that sample saturated. The window length can be rewritten at any time; a write starts a new window immediately.

The default window is 62,500,000 clocks, which is 500 ms at 125 MHz. The counter and the bus data are 32 bits by default.

Top module: `wheel_speed_counter`

## Requirements
- R1: After reset, register 0 (count) reads 0, register 1 (status) reads 0, and register 2 (window length) reads DEFAULT_WINDOW.
- R2: Each low-to-high transition of `sensor_in` adds exactly one to the window count, and a high-to-low transition adds nothing, however long the level is held. A transition reaches the counter three clock edges after it is sampled.
- R3: A sample event occurs on the WIN-th clock edge after reset or after a window write, where WIN is the value of register 2. It repeats every WIN edges after that. At each sample event the count is copied to register 0, and status bit 0 (valid) is set.
- R4: The counter restarts from zero at every sample event. A window with no sensor edges reports 0, whatever earlier windows held.
- R5: A rising edge that reaches the counter on the sample edge is left out of the latched value and is counted as the first edge of the new window.
- R6: The count saturates at its all-ones value (2^CNT_W - 1) instead of wrapping. If an edge arrives while the count is saturated, status bit 1 (overflow) is set at the next sample. That bit is clear again for a following window that does not saturate.
- R7: A read of register 0 clears status bit 0. A read of register 1 leaves both status bits unchanged.
- R8: A write to register 2 stores the new window length, restarts the window timer, discards the partial count without latching it, and leaves register 0 and the status bits as they were.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sensor_in | input | 1 | Asynchronous rotation sensor pulse |
| bus_addr | input | ADDR_W | Register select: 0 count, 1 status, 2 window length |
| bus_wr | input | 1 | Write strobe; only register 2 is writable |
| bus_rd | input | 1 | Read strobe; qualifies the read side effect of register 0 |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Combinational read data for `bus_addr` |

## Verification
The assertions assume the following about the inputs:
- A read strobe and a write strobe never occur in the same cycle.
- Each sensor level lasts long enough for the synchronizer to see it as a distinct high and low. The stimulus holds every level for at least three clocks.
- Sensor edges arrive slowly enough that, in a window without saturation, the counter never has to absorb two edges between consecutive samples of the synchronizer.

The stimulus keeps bus strobes one at a time and drives all inputs on the falling clock edge. The boundary scenario places a rising edge so that it reaches the counter exactly on the sample edge.

// File: rtl/wheel_speed_counter.sv
module wheel_speed_counter #(
  parameter int DATA_W         = 32,
  parameter int CNT_W          = 32,
  parameter int ADDR_W         = 2,
  parameter int DEFAULT_WINDOW = 62_500_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sensor_in,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata
);
  localparam logic [ADDR_W-1:0] REG_COUNT  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] REG_STATUS = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] REG_WINDOW = ADDR_W'(2);
  localparam logic [CNT_W-1:0]  CNT_FULL   = '1;

  logic [2:0]        sync_q;
  logic [DATA_W-1:0] win_q, tmr_q;
  logic [CNT_W-1:0]  cnt_q, lat_q;
  logic              ovf_run_q, ovf_lat_q, valid_q;

  wire rise   = sync_q[1] & ~sync_q[2];
  wire wr_win = bus_wr && bus_addr == REG_WINDOW;
  wire rd_cnt = bus_rd && bus_addr == REG_COUNT;
  wire at_end = (win_q <= DATA_W'(1)) || (tmr_q >= win_q - DATA_W'(1));
  wire sample = at_end && !wr_win;
  wire restart = sample || wr_win;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[1:0], sensor_in};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      win_q <= DATA_W'(DEFAULT_WINDOW);
      tmr_q <= '0;
    end else begin
      if (wr_win) win_q <= bus_wdata;
      tmr_q <= restart ? '0 : tmr_q + DATA_W'(1);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt_q     <= '0;
      ovf_run_q <= 1'b0;
    end else if (restart) begin
      cnt_q     <= CNT_W'(rise);
      ovf_run_q <= 1'b0;
    end else if (rise) begin
      if (cnt_q == CNT_FULL) ovf_run_q <= 1'b1;
      else                   cnt_q     <= cnt_q + CNT_W'(1);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      lat_q     <= '0;
      ovf_lat_q <= 1'b0;
      valid_q   <= 1'b0;
    end else begin
      if (sample) begin
        lat_q     <= cnt_q;
        ovf_lat_q <= ovf_run_q;
      end
      if (sample)      valid_q <= 1'b1;
      else if (rd_cnt) valid_q <= 1'b0;
    end

  always_comb
    case (bus_addr)
      REG_COUNT:  bus_rdata = DATA_W'(lat_q);
      REG_STATUS: bus_rdata = {{(DATA_W-2){1'b0}}, ovf_lat_q, valid_q};
      REG_WINDOW: bus_rdata = win_q;
      default:    bus_rdata = '0;
    endcase
endmodule

module wheel_speed_counter_checker #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sample,
  input logic              wr_win,
  input logic              rd_cnt,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [CNT_W-1:0]  lat_q,
  input logic              valid_q,
  input logic [DATA_W-1:0] tmr_q
);
  a_r8_rd_wr_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_wr));

  a_r3_latch_count: assert property (@(posedge clk) disable iff (!rst_n)
    sample |=> lat_q == $past(cnt_q));

  a_r3_valid_set: assert property (@(posedge clk) disable iff (!rst_n)
    sample |=> valid_q);

  a_r4_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
    sample |=> cnt_q <= CNT_W'(1));

  a_r6_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == {CNT_W{1'b1}} && !sample && !wr_win) |=> cnt_q == {CNT_W{1'b1}});

  a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_cnt && !sample) |=> !valid_q);

  a_r8_write_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    wr_win |=> (tmr_q == '0 && cnt_q <= CNT_W'(1) && $stable(lat_q)));
endmodule

bind wheel_speed_counter wheel_speed_counter_checker #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sample(sample), .wr_win(wr_win), .rd_cnt(rd_cnt),
  .bus_rd(bus_rd), .bus_wr(bus_wr), .cnt_q(cnt_q), .lat_q(lat_q),
  .valid_q(valid_q), .tmr_q(tmr_q)
);

// File: tb/wheel_speed_counter_test.sv
module wheel_speed_counter_test;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sensor_in = 1'b0;
  logic [1:0]    bus_addr = '0;
  logic          bus_wr = 1'b0;
  logic          bus_rd = 1'b0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;

  int n_checks = 0;
  int n_fail = 0;

  wheel_speed_counter #(.DATA_W(DW), .CNT_W(4), .ADDR_W(2), .DEFAULT_WINDOW(40)) uut (
    .clk(clk), .rst_n(rst_n), .sensor_in(sensor_in), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  always #4 clk = ~clk;

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(posedge clk);
    #1 bus_rd = 1'b0;
  endtask

  task automatic wr_window(input logic [DW-1:0] v);
    @(negedge clk);
    bus_addr = 2'd2; bus_wdata = v; bus_wr = 1'b1;
    @(posedge clk);
    #1 bus_wr = 1'b0;
  endtask

  task automatic pulse();
    @(negedge clk); sensor_in = 1'b1;
    repeat (3) @(negedge clk);
    sensor_in = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic wait_valid();
    logic [DW-1:0] s;
    s = '0;
    for (int i = 0; i < 2000 && !s[0]; i++) rd(2'd1, s);
  endtask

  task automatic setup_window(input logic [DW-1:0] v);
    logic [DW-1:0] d;
    wr_window(v);
    rd(2'd0, d);
  endtask

  task automatic t_reset();
    logic [DW-1:0] d;
    rd(2'd0, d); check("R1 count", d, 0);
    rd(2'd1, d); check("R1 status", d, 0);
    rd(2'd2, d); check("R1 window", d, 40);
  endtask

  task automatic t_basic();
    logic [DW-1:0] d;
    setup_window(80);
    rd(2'd2, d); check("R8 window readback", d, 80);
    repeat (3) pulse();
    @(negedge clk); sensor_in = 1'b1;
    repeat (20) @(negedge clk);
    sensor_in = 1'b0;
    wait_valid();
    rd(2'd1, d); check("R3 valid set", d, 1);
    rd(2'd1, d); check("R7 status read keeps valid", d, 1);
    rd(2'd0, d); check("R2 rising edges counted", d, 4);
    rd(2'd1, d); check("R7 count read clears valid", d, 0);
    wait_valid();
    rd(2'd0, d); check("R4 empty window reports zero", d, 0);
  endtask

  task automatic t_boundary();
    logic [DW-1:0] d;
    setup_window(40);
    wr_window(40);
    pulse(); pulse();
    repeat (26) @(negedge clk);
    sensor_in = 1'b1;
    repeat (3) @(negedge clk);
    sensor_in = 1'b0;
    wait_valid();
    rd(2'd0, d); check("R5 edge on sample edge excluded", d, 2);
    wait_valid();
    rd(2'd0, d); check("R5 edge carried into new window", d, 1);
  endtask

  task automatic t_saturate();
    logic [DW-1:0] d;
    setup_window(200);
    repeat (20) pulse();
    wait_valid();
    rd(2'd1, d); check("R6 overflow flagged", d, 3);
    rd(2'd0, d); check("R6 count saturates", d, 15);
    wait_valid();
    rd(2'd1, d); check("R6 overflow clears next window", d, 1);
    rd(2'd0, d); check("R6 quiet window after saturation", d, 0);
  endtask

  task automatic t_restart();
    logic [DW-1:0] d;
    setup_window(100);
    repeat (3) pulse();
    wr_window(100);
    rd(2'd1, d); check("R8 write does not latch", d, 0);
    repeat (2) pulse();
    wait_valid();
    rd(2'd0, d); check("R8 partial count discarded", d, 2);
  endtask

  initial begin
    #(8 * 200000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_boundary();
    t_saturate();
    t_restart();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule